// File: doc/BRIEF.md
# Pipelined Search-Tree Pattern Counter

This block tallies how often each member of a fixed set of known values turns up in a stream of input words. The known values sit in a binary search tree that is spread over a chain of pipeline levels: level k holds 2^(k-1) nodes in its own private storage, so every level can do a lookup in the same cycle. A new input word may be offered on every clock cycle. At each level it is compared with one node and steers either left or right, until it finds an equal node or runs out of levels.

Nodes are addressed by heap index: node 1 is the root, and the children of node h are 2h and 2h+1. A node in level k has an index with its highest set bit at position k-1. Software fills the tree through a load port before the stream starts. A result pulse comes out a fixed number of cycles after each input. A combinational read port returns the count held for any node.

Top module: `ptc_tree_counter`

## Requirements
- R1: After reset, every counter reads 0, out_hit and out_miss are low, and every tree node holds the value 0.
- R2: A cycle with ld_en high and ld_addr = h, with h from 1 to 2^LEVELS-1, writes ld_pat into node h and sets the counter of node h to 0. ld_addr = 0 names no node and changes nothing.
- R3: A search starts at node 1. At an unmatched node h, an input equal to the stored value matches h. An input smaller than the stored value moves to node 2h at the next level, and a larger input moves to node 2h+1.
- R4: Once an input has matched, its node index is carried through the remaining levels unchanged and no later level is compared. A copy of the same value stored deeper in the tree is never counted for that input.
- R5: The result for an input sampled at clock edge E appears at edge E+LEVELS as a one-cycle pulse. On a match, out_hit is 1 and out_node is the matched heap index. The matched counter advances at that same edge.
- R6: An input with no match by the last level gives an out_miss pulse with out_node = 0 and leaves every counter unchanged. out_hit and out_miss are never high together.
- R7: Inputs offered on consecutive cycles are all processed. Each one gives exactly one result pulse and at most one counter increment.
- R8: A counter that holds 2^CNT_W-1 stays at that value when it is incremented again.
- R9: rd_cnt combinationally returns the count of node rd_addr including any change that takes effect at the next edge, so a read in the cycle of an increment already shows the incremented value. rd_addr = 0 reads 0.
- R10: A cycle with in_valid low causes no result pulse and no counter change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is present this cycle |
| in_pat | input | PAT_W | Input word to look up |
| ld_en | input | 1 | Write one tree node |
| ld_addr | input | LEVELS | Heap index of the node written |
| ld_pat | input | PAT_W | Value stored into the node |
| rd_addr | input | LEVELS | Heap index of the counter read |
| rd_cnt | output | CNT_W | Count of node rd_addr, including the pending update |
| out_hit | output | 1 | Pulse: an input matched |
| out_miss | output | 1 | Pulse: an input matched no node |
| out_node | output | LEVELS | Matched heap index, 0 on a miss |

## Verification
The bench builds the block with LEVELS = 3, PAT_W = 4 and CNT_W = 3. That gives a seven-node tree and a 16-value input space, so every possible input word is streamed back to back against a fully loaded tree and compared with an arithmetic search model. The 3-bit counters reach saturation within ten inputs. The short pipeline lets the bench check every cycle of a single input's latency, including the read made in the cycle of its increment.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
    // Outcome of one node comparison
    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2
    } cmp_e;

    // Number of nodes held by a level (levels count from 1)
    function automatic int level_nodes(input int lvl);
        return 1 << (lvl - 1);
    endfunction
endpackage

// File: rtl/ptc_level.sv
`timescale 1ns/1ps
module ptc_level #(
    parameter int PAT_W  = 8,
    parameter int LEVELS = 4,
    parameter int LVL    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [LEVELS-1:0] ld_addr,
    input  logic [PAT_W-1:0]  ld_pat,
    input  logic              in_valid,
    input  logic [PAT_W-1:0]  in_pat,
    input  logic [LEVELS-1:0] in_node,
    input  logic              in_matched,
    output logic [LEVELS-1:0] out_node,
    output logic              out_matched
);
    import ptc_pkg::*;

    localparam int ENTRIES = level_nodes(LVL);
    localparam int MEM_N   = (ENTRIES < 2) ? 2 : ENTRIES;
    localparam int IDX_W   = $clog2(MEM_N);
    localparam logic [LEVELS-1:0] BASE = LEVELS'(ENTRIES);

    logic [PAT_W-1:0] mem_q [MEM_N];
    logic [PAT_W-1:0] mem_d [MEM_N];
    logic             wr_hit;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [PAT_W-1:0] key;
    cmp_e             cmp;

    always_comb begin
        wr_hit = ld_en && ((ld_addr >> (LVL - 1)) == LEVELS'(1));
        wr_idx = IDX_W'(ld_addr - BASE);
        rd_idx = IDX_W'(in_node - BASE);
        mem_d  = mem_q;
        if (wr_hit) begin
            mem_d[wr_idx] = ld_pat;
        end
        key = mem_q[rd_idx];
        if (in_pat == key) begin
            cmp = CMP_EQ;
        end else if (in_pat < key) begin
            cmp = CMP_LT;
        end else begin
            cmp = CMP_GT;
        end
        out_node    = in_node;
        out_matched = in_matched;
        if (in_valid && !in_matched) begin
            if (cmp == CMP_EQ) begin
                out_matched = 1'b1;
            end else if (LVL < LEVELS) begin
                out_node = (in_node << 1) | LEVELS'(cmp == CMP_GT);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '{default: '0};
        end else begin
            mem_q <= mem_d;
        end
    end

    // R2: a load aimed at this level is stored at the addressed slot
    assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> mem_q[$past(wr_idx)] == $past(ld_pat));
endmodule

// File: rtl/ptc_counters.sv
`timescale 1ns/1ps
module ptc_counters #(
    parameter int LEVELS = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_en,
    input  logic [LEVELS-1:0] inc_addr,
    input  logic              clr_en,
    input  logic [LEVELS-1:0] clr_addr,
    input  logic [LEVELS-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_cnt
);
    localparam int SLOTS = 1 << LEVELS;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [SLOTS];
    logic [CNT_W-1:0] cnt_d [SLOTS];

    always_comb begin
        cnt_d = cnt_q;
        if (inc_en && (cnt_q[inc_addr] != CNT_MAX)) begin
            cnt_d[inc_addr] = cnt_q[inc_addr] + CNT_W'(1);
        end
        if (clr_en) begin
            cnt_d[clr_addr] = '0;
        end
        cnt_d[0] = '0;
        rd_cnt   = cnt_d[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '{default: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R8: a full counter never wraps when hit again
    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !(clr_en && clr_addr == inc_addr) && cnt_q[inc_addr] == CNT_MAX)
        |=> cnt_q[$past(inc_addr)] == CNT_MAX);

    // R2: a load clears the node counter at the next edge
    assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> cnt_q[$past(clr_addr)] == '0);
endmodule

// File: rtl/ptc_tree_counter.sv
`timescale 1ns/1ps
module ptc_tree_counter #(
    parameter int PAT_W  = 8,
    parameter int LEVELS = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PAT_W-1:0]  in_pat,
    input  logic              ld_en,
    input  logic [LEVELS-1:0] ld_addr,
    input  logic [PAT_W-1:0]  ld_pat,
    input  logic [LEVELS-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic              out_hit,
    output logic              out_miss,
    output logic [LEVELS-1:0] out_node
);
    typedef struct packed {
        logic              valid;
        logic [PAT_W-1:0]  pat;
        logic [LEVELS-1:0] node;
        logic              matched;
    } stage_t;

    typedef struct packed {
        logic [LEVELS-1:0] node;
        logic              matched;
    } step_t;

    typedef struct packed {
        logic              hit;
        logic              miss;
        logic [LEVELS-1:0] node;
    } result_t;

    stage_t  [LEVELS:1] st_q;
    stage_t  [LEVELS:1] st_d;
    step_t   [LEVELS:1] res;
    result_t            out_q;
    result_t            out_d;
    logic               clr_en;

    for (genvar k = 1; k <= LEVELS; k++) begin : g_lvl
        ptc_level #(
            .PAT_W (PAT_W),
            .LEVELS(LEVELS),
            .LVL   (k)
        ) u_level (
            .clk        (clk),
            .rst_n      (rst_n),
            .ld_en      (ld_en),
            .ld_addr    (ld_addr),
            .ld_pat     (ld_pat),
            .in_valid   (st_q[k].valid),
            .in_pat     (st_q[k].pat),
            .in_node    (st_q[k].node),
            .in_matched (st_q[k].matched),
            .out_node   (res[k].node),
            .out_matched(res[k].matched)
        );
    end

    always_comb begin
        st_d[1].valid   = in_valid;
        st_d[1].pat     = in_pat;
        st_d[1].node    = LEVELS'(1);
        st_d[1].matched = 1'b0;
        for (int k = 2; k <= LEVELS; k++) begin
            st_d[k].valid   = st_q[k-1].valid;
            st_d[k].pat     = st_q[k-1].pat;
            st_d[k].node    = res[k-1].node;
            st_d[k].matched = res[k-1].matched;
        end
        out_d.hit  = st_q[LEVELS].valid && res[LEVELS].matched;
        out_d.miss = st_q[LEVELS].valid && !res[LEVELS].matched;
        out_d.node = out_d.hit ? res[LEVELS].node : '0;
        clr_en     = ld_en && (ld_addr != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            out_q <= '0;
        end else begin
            st_q  <= st_d;
            out_q <= out_d;
        end
    end

    ptc_counters #(
        .LEVELS(LEVELS),
        .CNT_W (CNT_W)
    ) u_counters (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (out_d.hit),
        .inc_addr(res[LEVELS].node),
        .clr_en  (clr_en),
        .clr_addr(ld_addr),
        .rd_addr (rd_addr),
        .rd_cnt  (rd_cnt)
    );

    assign out_hit  = out_q.hit;
    assign out_miss = out_q.miss;
    assign out_node = out_q.node;

    // R6: one result kind per input
    assert_hit_miss_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_hit && out_miss));

    // R6: a miss carries no node index
    assert_miss_node_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> out_node == '0);

    for (genvar k = 2; k <= LEVELS; k++) begin : g_chk
        // R3: an unmatched word at stage k points at a node of level k
        assert_walk_depth_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[k].valid && !st_q[k].matched) |-> ((st_q[k].node >> (k - 1)) == LEVELS'(1)));
        // R4: a matched word carries a node from an earlier level
        assert_match_depth_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q[k].valid && st_q[k].matched)
            |-> (st_q[k].node != '0 && (st_q[k].node >> (k - 1)) == '0));
    end
endmodule

// File: tb/ptc_tree_counter_bench.sv
`timescale 1ns/1ps
module ptc_tree_counter_bench;
    localparam int L    = 3;
    localparam int PW   = 4;
    localparam int CW   = 3;
    localparam int NN   = (1 << L) - 1;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_pat = '0;
    logic          ld_en = 1'b0;
    logic [L-1:0]  ld_addr = '0;
    logic [PW-1:0] ld_pat = '0;
    logic [L-1:0]  rd_addr = '0;
    logic [CW-1:0] rd_cnt;
    logic          out_hit;
    logic          out_miss;
    logic [L-1:0]  out_node;

    int total = 0;
    int bad = 0;
    int hits_seen = 0;
    int miss_seen = 0;
    int keys [1:NN];
    int exp_cnt [1:NN];

    always #4 clk = ~clk;

    ptc_tree_counter #(.PAT_W(PW), .LEVELS(L), .CNT_W(CW)) u_ptc_tree_counter (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pat(in_pat),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_pat(ld_pat), .rd_addr(rd_addr),
        .rd_cnt(rd_cnt), .out_hit(out_hit), .out_miss(out_miss), .out_node(out_node)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        if (out_hit) hits_seen++;
        if (out_miss) miss_seen++;
    endtask

    task automatic read_cnt(input int a, output int v);
        @(negedge clk);
        rd_addr = L'(a);
        #1;
        v = int'(rd_cnt);
    endtask

    function automatic int model_find(input int p);
        int h = 1;
        for (int lv = 1; lv <= L; lv++) begin
            if (p == keys[h]) return h;
            if (lv == L) return 0;
            h = (p < keys[h]) ? 2 * h : 2 * h + 1;
        end
        return 0;
    endfunction

    function automatic void model_count(input int p);
        int h = model_find(p);
        if (h != 0 && exp_cnt[h] < CMAX) exp_cnt[h]++;
    endfunction

    task automatic load(input int h, input int v);
        ld_en = 1'b1;
        ld_addr = L'(h);
        ld_pat = PW'(v);
        tick();
        ld_en = 1'b0;
        if (h != 0) begin
            keys[h] = v;
            exp_cnt[h] = 0;
        end
    endtask

    // drive one word, return just after its result edge
    task automatic send_one(input int p);
        in_valid = 1'b1;
        in_pat = PW'(p);
        tick();
        in_valid = 1'b0;
        model_count(p);
        repeat (L) tick();
    endtask

    task automatic compare_all(input string req);
        int v;
        for (int h = 1; h <= NN; h++) begin
            read_cnt(h, v);
            check(v == exp_cnt[h], req, v, exp_cnt[h]);
        end
    endtask

    initial begin
        int v;
        for (int h = 1; h <= NN; h++) begin
            keys[h] = 0;
            exp_cnt[h] = 0;
        end
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        check(out_hit == 1'b0 && out_miss == 1'b0, "R1 outputs idle", int'(out_hit) + int'(out_miss), 0);
        compare_all("R1 counters zero");
        // R1: cleared tree holds 0, so word 0 matches the root
        send_one(0);
        check(out_hit && out_node == 1, "R1 zero tree root match", int'(out_node), 1);

        // R2: load a sorted tree, which also clears the counters
        for (int h = 1; h <= NN; h++) load(h, 2 * (h == 1 ? 4 : 0));
        begin
            int vals [1:NN] = '{8, 4, 12, 2, 6, 10, 14};
            for (int h = 1; h <= NN; h++) load(h, vals[h]);
        end
        load(0, 5);
        compare_all("R2 load clears counters");

        // R5 and R9: single word, cycle by cycle
        in_valid = 1'b1;
        in_pat = PW'(6);
        tick();
        in_valid = 1'b0;
        for (int c = 1; c < L; c++) begin
            tick();
            check(!out_hit && !out_miss, "R5 no early result", int'(out_hit), 0);
        end
        read_cnt(5, v);
        check(v == 1, "R9 read shows pending increment", v, 1);
        tick();
        check(out_hit && out_node == 5, "R5 hit at latency LEVELS", int'(out_node), 5);
        model_count(6);
        read_cnt(5, v);
        check(v == 1, "R5 counter advanced", v, 1);
        tick();
        check(!out_hit && !out_miss, "R5 single-cycle pulse", int'(out_hit), 0);

        // R3: left-left path
        send_one(2);
        check(out_hit && out_node == 4, "R3 smaller goes to 2h", int'(out_node), 4);
        send_one(10);
        check(out_hit && out_node == 6, "R3 larger goes to 2h+1", int'(out_node), 6);

        // R10: invalid cycles do nothing
        hits_seen = 0;
        miss_seen = 0;
        for (int c = 0; c < 6; c++) begin
            in_pat = PW'(8);
            tick();
        end
        repeat (L) tick();
        check(hits_seen == 0 && miss_seen == 0, "R10 no pulse when idle", hits_seen + miss_seen, 0);
        compare_all("R10 counters untouched");

        // R7 and R6: every input word, back to back
        hits_seen = 0;
        miss_seen = 0;
        begin
            int exp_hits = 0;
            for (int p = 0; p < (1 << PW); p++) begin
                in_valid = 1'b1;
                in_pat = PW'(p);
                tick();
                model_count(p);
                if (model_find(p) != 0) exp_hits++;
            end
            in_valid = 1'b0;
            repeat (L + 1) tick();
            check(hits_seen == exp_hits, "R7 hit pulses in sweep", hits_seen, exp_hits);
            check(miss_seen == (1 << PW) - exp_hits, "R6 miss pulses in sweep", miss_seen, (1 << PW) - exp_hits);
        end
        compare_all("R7 counts after sweep");

        // R6: a miss changes no counter
        send_one(13);
        check(out_miss && out_node == 0, "R6 miss pulse", int'(out_miss), 1);
        compare_all("R6 counters unchanged");

        // R8: saturation at the root
        for (int c = 0; c < 10; c++) begin
            in_valid = 1'b1;
            in_pat = PW'(8);
            tick();
            model_count(8);
        end
        in_valid = 1'b0;
        repeat (L + 1) tick();
        read_cnt(1, v);
        check(v == CMAX, "R8 saturates", v, CMAX);

        // R4: duplicate deeper copy is never counted
        load(7, 8);
        send_one(8);
        check(out_hit && out_node == 1, "R4 first match wins", int'(out_node), 1);
        read_cnt(7, v);
        check(v == 0, "R4 deeper copy not counted", v, 0);
        send_one(14);
        check(out_miss, "R3 removed key now misses", int'(out_miss), 1);
        compare_all("R4 counts");

        // R9: address 0 reads zero; R2: reload clears
        read_cnt(0, v);
        check(v == 0, "R9 address zero", v, 0);
        load(1, 8);
        read_cnt(1, v);
        check(v == 0, "R2 reload clears counter", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule